// File: doc/BRIEF.md
# Word-Serial Montgomery Reducer Without Final Subtraction

The block reduces a 2n-word integer x to an n-word value z with z·2^(32n) ≡ x (mod q). It uses radix-2^32 Montgomery reduction, scanned column by column. One 32×32 multiply-accumulate is issued per clock into a 96-bit running accumulator. The low-half columns produce the quotient digits, and the high-half columns produce the result words. The result stays in the redundant range [0, 2q), so it can feed straight back into a chain of Montgomery multiplications. Any conversion into or out of Montgomery form, and any final canonicalising subtraction, belong to the caller.

A caller presents x, the modulus q and the constant µ = −q^(−1) mod 2^32, then pulses `start_i`. The block copies all operands into its own word register files on the accepting edge, so the inputs may change right after that edge. When the last result word has been written, `done_o` pulses for one cycle and `z_o` holds the result until the next accepted start. The word count n is the parameter `N`.

Top module: `mont_reduce`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `z_o` is all zeros.
- R2: A high `start_i` on an edge where `busy_o` is low is accepted. x, q and µ are captured on that edge, and `busy_o` is high from the next cycle. Later changes on `x_i`, `q_i` and `mu_i` do not affect the running operation.
- R3: `done_o` is high for exactly one cycle. It rises on the edge n²+n cycles after the accepting edge, and `busy_o` falls on that same edge. `busy_o` and `done_o` are never high together.
- R4: Operand words are little-endian: word k of `x_i`, `q_i` and `z_o` occupies bits [32k+31:32k]. Take a legal input: q odd, 2^(32(n−1)) < q, 4q < 2^(32n), 0 ≤ x ≤ (2q−1)², `mu_i` = −q^(−1) mod 2^32. Let m = (x·(−q^(−1))) mod 2^(32n). Then z = (x + m·q)/2^(32n), which implies z·2^(32n) ≡ x (mod q) and z < 2q.
- R5: No final subtraction is applied: a result lying in [q, 2q) is returned as is.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running operation's result and completion cycle are unchanged.
- R7: While `busy_o` is low, `z_o` does not change.
- R8: A `start_i` high in the cycle where `done_o` is high is accepted on the following edge, with no idle gap beyond that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a reduction |
| x_i | input | 64·N | Integer to reduce, 2N little-endian words |
| q_i | input | 32·N | Odd modulus, N little-endian words |
| mu_i | input | 32 | −q^(−1) mod 2^32 |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| z_o | output | 32·N | Result words, valid from the `done_o` cycle |

## Verification
The checker watches the control timing on every cycle: the single-cycle completion pulse, its fixed distance from the accepting edge, busy rising after an accepted start, and the result staying still while idle. It also checks on every completion that the result lies below twice the captured modulus. Only the bench scenarios can show that the result value is exactly correct. The scenarios cover random and boundary moduli, zero and maximal inputs, a result built to land in [q, 2q), a start pulse with altered operands during a busy run, and back-to-back operations. In each one the bench compares the result against an independent wide-integer computation.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_CLOSE, ST_LAST} seq_st_e;
  typedef enum logic [2:0] {OP_NONE, OP_MAC, OP_RED, OP_CARRY, OP_LAST} dp_op_e;
endpackage

// File: rtl/mont_seq.sv
module mont_seq
  import mont_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  output dp_op_e                op_o,
  output logic [$clog2(2*N)-1:0] col_o,
  output logic [((N>1)?$clog2(N):1)-1:0] jj_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int CW = $clog2(2*N);
  localparam int JW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] COL_N   = CW'(N);
  localparam logic [CW-1:0] COL_NM1 = CW'(N-1);
  localparam logic [CW-1:0] COL_PEN = CW'(2*N-2);
  localparam logic [CW-1:0] COL_END = CW'(2*N-1);

  seq_st_e        st_q;
  logic [CW-1:0]  col_q;
  logic [JW-1:0]  jj_q;
  logic           done_q;

  // first and last quotient-digit index feeding column c
  function automatic logic [JW-1:0] first_j(input logic [CW-1:0] c);
    return (c < COL_N) ? '0 : JW'(c - COL_NM1);
  endfunction

  function automatic logic [JW-1:0] last_j(input logic [CW-1:0] c);
    return (c < COL_N) ? JW'(c - CW'(1)) : JW'(N-1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      jj_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept_i) begin
          st_q  <= ST_CLOSE;          // column 0 has no products
          col_q <= '0;
          jj_q  <= '0;
        end
        ST_MAC: begin
          if (jj_q == last_j(col_q)) st_q <= ST_CLOSE;
          else                       jj_q <= jj_q + JW'(1);
        end
        ST_CLOSE: begin
          if (col_q == COL_PEN) begin
            st_q  <= ST_LAST;
            col_q <= COL_END;
          end else begin
            st_q  <= ST_MAC;
            col_q <= col_q + CW'(1);
            jj_q  <= first_j(col_q + CW'(1));
          end
        end
        ST_LAST: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_MAC:   op_o = OP_MAC;
      ST_CLOSE: op_o = (col_q < COL_N) ? OP_RED : OP_CARRY;
      ST_LAST:  op_o = OP_LAST;
      default:  op_o = OP_NONE;
    endcase
  end

  assign col_o  = col_q;
  assign jj_o   = jj_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/mont_acc.sv
module mont_acc
  import mont_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  dp_op_e       op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] x_word_i,
  input  logic [W-1:0] mu_i,
  input  logic [W-1:0] q0_i,
  output logic [W-1:0] word_o
);
  localparam int AW = 3 * W;

  logic [AW-1:0]  acc_q;
  logic [AW-1:0]  sum_x;
  logic [AW-1:0]  red;
  logic [W-1:0]   m_dig;
  logic [2*W-1:0] mq;
  logic [2*W-1:0] ab;

  always_comb begin
    sum_x  = acc_q + AW'(x_word_i);
    m_dig  = sum_x[W-1:0] * mu_i;      // quotient digit, same step
    mq     = {{W{1'b0}}, m_dig} * {{W{1'b0}}, q0_i};
    ab     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    red    = sum_x + AW'(mq);           // low word cancels to zero
    word_o = (op_i == OP_RED) ? m_dig : sum_x[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else begin
      unique case (op_i)
        OP_MAC:   acc_q <= acc_q + AW'(ab);
        OP_RED:   acc_q <= red >> W;
        OP_CARRY: acc_q <= sum_x >> W;
        OP_LAST:  acc_q <= '0;
        default:  acc_q <= acc_q;
      endcase
    end
  end
endmodule

// File: rtl/mont_reduce.sv
module mont_reduce
  import mont_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2*N*W-1:0] x_i,
  input  logic [N*W-1:0]   q_i,
  input  logic [W-1:0]     mu_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [N*W-1:0]   z_o
);
  localparam int CW = $clog2(2*N);
  localparam int JW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] COL_N = CW'(N);

  logic [2*N*W-1:0] x_q;
  logic [N*W-1:0]   q_q;
  logic [W-1:0]     mu_q;
  logic [N*W-1:0]   z_q;

  dp_op_e        op;
  logic [CW-1:0] col;
  logic [JW-1:0] jj;
  logic [JW-1:0] q_idx;
  logic [JW-1:0] wr_idx;
  logic [W-1:0]  mul_a, mul_b, x_word, res_word;
  logic          busy, accept, wr_en;

  assign accept = start_i && !busy;

  mont_seq #(.N(N)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .op_o     (op),
    .col_o    (col),
    .jj_o     (jj),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  assign q_idx  = JW'(col - CW'(jj));
  assign wr_idx = (col >= COL_N) ? JW'(col - COL_N) : JW'(col);
  assign mul_a  = z_q[jj*W +: W];
  assign mul_b  = q_q[q_idx*W +: W];
  assign x_word = x_q[col*W +: W];
  assign wr_en  = (op == OP_RED) || (op == OP_CARRY) || (op == OP_LAST);

  mont_acc #(.W(W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .op_i     (op),
    .a_i      (mul_a),
    .b_i      (mul_b),
    .x_word_i (x_word),
    .mu_i     (mu_q),
    .q0_i     (q_q[W-1:0]),
    .word_o   (res_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      q_q  <= '0;
      mu_q <= '0;
    end else if (accept) begin
      x_q  <= x_i;
      q_q  <= q_i;
      mu_q <= mu_i;
    end
  end

  // quotient digits and result words share one file; column order keeps them apart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    z_q <= '0;
    else if (wr_en) z_q[wr_idx*W +: W] <= res_word;
  end

  assign busy_o = busy;
  assign z_o    = z_q;
endmodule

// File: rtl/mont_reduce_chk.sv
module mont_reduce_chk #(
  parameter int N = 4,
  parameter int W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N*W-1:0] z_o,
  input logic [N*W-1:0] q_flat_i
);
  localparam int LAT = N * N + N;

  logic [31:0] lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_cnt <= '0;
    else if (start_i && !busy_o)  lat_cnt <= '0;
    else if (busy_o)              lat_cnt <= lat_cnt + 32'd1;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == 32'(LAT)));

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R4
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, z_o} < {q_flat_i, 1'b0}));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(z_o));
endmodule

bind mont_reduce mont_reduce_chk #(.N(N), .W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .z_o      (z_o),
  .q_flat_i (q_q)
);

// File: tb/tb_mont_reduce.sv
module tb_mont_reduce;
  localparam int N   = 4;
  localparam int W   = 32;
  localparam int RW  = N * W;
  localparam int XW  = 2 * RW;
  localparam int BW  = 2 * RW + 2;
  localparam int LAT = N * N + N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [XW-1:0] x_i = '0;
  logic [RW-1:0] q_i = '0;
  logic [W-1:0]  mu_i = '0;
  logic          busy_o, done_o;
  logic [RW-1:0] z_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mont_reduce #(.N(N), .W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .x_i(x_i), .q_i(q_i),
    .mu_i(mu_i), .busy_o(busy_o), .done_o(done_o), .z_o(z_o)
  );

  // cycle model of the handshake
  logic m_busy, m_done;
  int   m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start_i) begin
        m_busy <= 1'b1; m_left <= LAT;
      end else if (m_busy) begin
        if (m_left == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
        m_left <= m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (busy_o !== m_busy || done_o !== m_done) begin
        n_fail++;
        $display("FAIL R2 R3 R6 R8 handshake: busy=%b done=%b expected busy=%b done=%b",
                 busy_o, done_o, m_busy, m_done);
      end
    end
  end

  function automatic logic [RW-1:0] neg_inv(input logic [RW-1:0] q);
    logic [RW-1:0] inv, t;
    inv = 1;
    for (int k = 0; k < 12; k++) begin
      t = q * inv;
      t = RW'(2) - t;
      inv = inv * t;
    end
    return ~inv + RW'(1);
  endfunction

  function automatic logic [RW-1:0] ref_z(input logic [XW-1:0] x, input logic [RW-1:0] q);
    logic [RW-1:0] m;
    logic [BW-1:0] big;
    m = x[RW-1:0] * neg_inv(q);
    big = BW'(x) + BW'(m) * BW'(q);
    return big[RW +: RW];
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [XW-1:0] x, input logic [RW-1:0] q);
    logic [XW-1:0] lhs, rhs;
    check("R4 value", z_o, ref_z(x, q));
    lhs = (XW'(z_o) << RW) % XW'(q);
    rhs = x % XW'(q);
    n_chk++;
    if (lhs !== rhs) begin
      n_fail++;
      $display("FAIL R4 congruence: actual=%h expected=%h", lhs, rhs);
    end
    n_chk++;
    if (!((RW+1)'(z_o) < ((RW+1)'(q) << 1))) begin
      n_fail++;
      $display("FAIL R4 bound: actual=%h expected below %h", z_o, (RW+1)'(q) << 1);
    end
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic run_op(input logic [XW-1:0] x, input logic [RW-1:0] q, input int spoil_at);
    logic [RW-1:0] nq;
    nq = neg_inv(q);
    @(negedge clk);
    x_i = x; q_i = q; mu_i = nq[W-1:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (spoil_at > 0) begin
      repeat (spoil_at) @(negedge clk);
      x_i = ~x; mu_i = ~nq[W-1:0]; start_i = 1'b1;   // R6 stray start
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    check_result(x, q);
  endtask

  function automatic logic [RW-1:0] rand_q();
    logic [RW-1:0] q;
    for (int k = 0; k < N; k++) q[k*W +: W] = $urandom;
    q[RW-W +: W] = ($urandom % 32'h3FFF_FFFF) + 32'd1;
    q[0] = 1'b1;
    return q;
  endfunction

  function automatic logic [XW-1:0] rand_x(input logic [RW-1:0] q);
    logic [XW-1:0] x, mx;
    for (int k = 0; k < 2*N; k++) x[k*W +: W] = $urandom;
    mx = (XW'(q) * 2 - 1) * (XW'(q) * 2 - 1);
    return x % (mx + 1);
  endfunction

  function automatic logic [XW-1:0] max_x(input logic [RW-1:0] q);
    return (XW'(q) * 2 - 1) * (XW'(q) * 2 - 1);
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
    $finish;
  end

  initial begin
    logic [RW-1:0] q, hold;
    logic [XW-1:0] x, xb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 z_o", z_o, '0);
    check("R1 busy_o", RW'(busy_o), '0);
    check("R1 done_o", RW'(done_o), '0);

    // R4 zero input
    q = rand_q();
    run_op('0, q, 0);
    check("R4 zero", z_o, '0);

    // R4 boundary moduli with maximal input
    q = (RW'(1) << (RW-2)) - RW'(1);
    run_op(max_x(q), q, 0);
    q = (RW'(1) << (RW-W)) + RW'(1);
    run_op(max_x(q), q, 0);

    // R5 constructed result q+5, which needs no subtraction
    q = rand_q();
    x = (XW'(5) << RW) + XW'(q);
    run_op(x, q, 0);
    check("R5 redundant", z_o, q + RW'(5));

    // R4 random
    for (int k = 0; k < 25; k++) begin
      q = rand_q();
      run_op(rand_x(q), q, 0);
    end

    // R6 stray start with altered operands during a busy run
    q = rand_q();
    run_op(rand_x(q), q, 5);

    // R7 hold while idle
    hold = z_o;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      x_i = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      q_i = rand_q();
      check("R7 idle hold", z_o, hold);
    end

    // R8 back-to-back
    q = rand_q();
    x = rand_x(q);
    xb = rand_x(q);
    @(negedge clk);
    x_i = x; q_i = q; mu_i = neg_inv(q)[W-1:0]; start_i = 1'b1;
    @(negedge clk);
    wait_done();
    check_result(x, q);
    x_i = xb;                           // start still high in done cycle
    @(negedge clk);
    start_i = 1'b0;
    check("R8 busy again", RW'(busy_o), RW'(1));
    wait_done();
    check_result(xb, q);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
    $finish;
  end
endmodule